// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block limits the peak current in a motor winding. While the drive is on, a digital over-current trip from an external comparator switches the drive off for a fixed number of timing ticks. When that interval has run out, the drive turns back on by itself. After every turn-on, the trip input is masked for a blanking interval. This keeps the current spike from diode reverse recovery from being read as an over-current event.

An external PWM enable sits above the chopper. When it is low, every driver is off. When it is held high, the current limit alone sets the torque. Every off period started by the PWM input lasts at least a minimum number of ticks, so the bootstrap supply can recharge. A second output tells the commutation stage which type of decay to use during an off period: slow (only the high-side switch opens) or fast (every switch of the active pair opens). All intervals are counted in cycles where `tick_en` is high, and they are set by parameters.

Top module: `chop_ctrl`

## Requirements
- R1: During reset and right after it, `drive_on_o` and `recirc_slow_o` are 0. After reset is released, the drive stays off for MIN_OFF_TICKS tick cycles. It turns on at the clock edge that consumes the last of those ticks, provided `pwm_en` is high.
- R2: A trip seen while the drive is on, `pwm_en` is high and blanking has ended turns `drive_on_o` off at the next clock edge. The drive stays off for OFF_TICKS tick cycles and turns back on at the edge of the last tick, provided `pwm_en` is high.
- R3: After each turn-on, the trip input is ignored until BLANK_TICKS tick cycles have passed. A trip in the cycle after the last blanking tick is honoured.
- R4: A trip during an off interval has no effect and does not restart the interval.
- R5: An off interval is never shortened. If `pwm_en` is low when the interval ends, the drive stays off and turns on at the first clock edge at which `pwm_en` is high.
- R6: `pwm_en` low while the drive is on turns the drive off at the next edge. That off period lasts at least MIN_OFF_TICKS tick cycles, however short the low pulse is.
- R7: If `pwm_en` goes low during a trip-caused off interval, the block switches to full off (`recirc_slow_o` = 0). The remaining interval is kept.
- R8: `recirc_slow_o` is 1 only during a trip-caused off interval whose trip occurred with `decay_slow_i` = 1 and while `pwm_en` is high. A trip with `decay_slow_i` = 0 gives `recirc_slow_o` = 0 (fast decay).
- R9: The off and blanking counts advance only in cycles where `tick_en` = 1. Cycles without a tick leave them unchanged.
- R10: Blanking is reloaded on every off-to-on transition, including a turn-on that follows a PWM-commanded off period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timing tick; the off and blanking counts advance on it |
| pwm_en | input | 1 | External PWM enable; low forces every driver off |
| trip_i | input | 1 | Over-current comparator trip |
| decay_slow_i | input | 1 | 1 = slow decay, 0 = fast decay, sampled on a trip |
| drive_on_o | output | 1 | Selected drivers enabled |
| recirc_slow_o | output | 1 | 1 = open only the high-side switch during the current off period |

## Verification
Both outputs come straight from registers. An input change applied before a clock edge therefore shows up at the outputs one edge later, and an interval of N ticks with a tick every cycle spans exactly N cycles. The driver applies each cycle's inputs at the falling edge and queues the outputs expected after the next rising edge. The monitor pops and compares that entry shortly after the rising edge. No check waits on an event, so every expected value is tied to one particular edge, such as the fourth cycle after a turn-on for the first trip that gets through blanking.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    ST_ON       = 2'd0,
    ST_TRIP_OFF = 2'd1,
    ST_PWM_OFF  = 2'd2
  } chop_state_e;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             cnt_zero,
  output logic             expire
);
  localparam logic [CNT_W-1:0] RST_LD = CNT_W'(RST_VAL);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (tick_en && (cnt_q != '0))
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_LD;
    else        cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);
  assign expire   = cnt_zero || (tick_en && (cnt_q == ONE));

  // R9: without a tick and without a load the count holds
  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick_en) |=> $stable(cnt_q));

  // R2: a load takes the programmed value
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int OFF_TICKS     = 20,
  parameter int BLANK_TICKS   = 4,
  parameter int MIN_OFF_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_en,
  input  logic             trip_i,
  input  logic             decay_slow_i,
  input  logic             off_expire,
  input  logic             blank_zero,
  output logic             off_load,
  output logic [CNT_W-1:0] off_val,
  output logic             blank_load,
  output logic [CNT_W-1:0] blank_val,
  output logic             drive_on_o,
  output logic             recirc_slow_o
);
  localparam logic [CNT_W-1:0] OFF_LD   = CNT_W'(OFF_TICKS);
  localparam logic [CNT_W-1:0] MIN_LD   = CNT_W'(MIN_OFF_TICKS);
  localparam logic [CNT_W-1:0] BLANK_LD = CNT_W'(BLANK_TICKS);

  chop_state_e state_q, state_d;
  logic        slow_q, slow_d;

  always_comb begin
    state_d    = state_q;
    slow_d     = slow_q;
    off_load   = 1'b0;
    off_val    = MIN_LD;
    blank_load = 1'b0;
    unique case (state_q)
      ST_ON: begin
        if (!pwm_en) begin
          state_d  = ST_PWM_OFF;
          off_load = 1'b1;
          off_val  = MIN_LD;
        end else if (trip_i && blank_zero) begin
          state_d  = ST_TRIP_OFF;
          off_load = 1'b1;
          off_val  = OFF_LD;
          slow_d   = decay_slow_i;
        end
      end
      ST_TRIP_OFF: begin
        if (off_expire && pwm_en) begin
          state_d    = ST_ON;
          blank_load = 1'b1;
        end else if (!pwm_en) begin
          state_d = ST_PWM_OFF;
        end
      end
      ST_PWM_OFF: begin
        if (off_expire && pwm_en) begin
          state_d    = ST_ON;
          blank_load = 1'b1;
        end
      end
      default: state_d = ST_PWM_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWM_OFF;
      slow_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slow_q  <= slow_d;
    end
  end

  assign blank_val     = BLANK_LD;
  assign drive_on_o    = (state_q == ST_ON);
  assign recirc_slow_o = (state_q == ST_TRIP_OFF) && slow_q;

  // R3: a trip inside the blanking window keeps the drive on
  p_blank_masks_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && pwm_en && !blank_zero) |=> (state_q == ST_ON));

  // R5: no turn-on before the off interval has run out
  p_no_early_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_ON && !off_expire) |=> (state_q != ST_ON));

  // R6: PWM low while on leads to a PWM-commanded off
  p_pwm_low_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && !pwm_en) |=> (state_q == ST_PWM_OFF));

  // R7: PWM low during a trip off leaves slow recirculation
  p_pwm_low_full_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIP_OFF && !pwm_en) |=> !recirc_slow_o);
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int CNT_W         = 8,
  parameter int OFF_TICKS     = 20,
  parameter int BLANK_TICKS   = 4,
  parameter int MIN_OFF_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic pwm_en,
  input  logic trip_i,
  input  logic decay_slow_i,
  output logic drive_on_o,
  output logic recirc_slow_o
);
  logic             off_load, off_expire, off_zero;
  logic [CNT_W-1:0] off_val;
  logic             blank_load, blank_zero, blank_expire;
  logic [CNT_W-1:0] blank_val;

  chop_timer #(.CNT_W(CNT_W), .RST_VAL(MIN_OFF_TICKS)) u_off_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load     (off_load),
    .load_val (off_val),
    .cnt_zero (off_zero),
    .expire   (off_expire)
  );

  chop_timer #(.CNT_W(CNT_W), .RST_VAL(0)) u_blank_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load     (blank_load),
    .load_val (blank_val),
    .cnt_zero (blank_zero),
    .expire   (blank_expire)
  );

  chop_fsm #(
    .CNT_W(CNT_W), .OFF_TICKS(OFF_TICKS),
    .BLANK_TICKS(BLANK_TICKS), .MIN_OFF_TICKS(MIN_OFF_TICKS)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_en        (pwm_en),
    .trip_i        (trip_i),
    .decay_slow_i  (decay_slow_i),
    .off_expire    (off_expire),
    .blank_zero    (blank_zero),
    .off_load      (off_load),
    .off_val       (off_val),
    .blank_load    (blank_load),
    .blank_val     (blank_val),
    .drive_on_o    (drive_on_o),
    .recirc_slow_o (recirc_slow_o)
  );

  // R8: slow recirculation is only ever flagged while the drive is off
  p_slow_only_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recirc_slow_o |-> !drive_on_o);

  // R10: every turn-on starts a blanking window unless it is empty
  p_turn_on_blanks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_on_o) |-> (!blank_zero || blank_val == '0));

  logic unused_ok;
  assign unused_ok = off_zero ^ blank_expire;
endmodule

// File: tb/chop_ctrl_tb_top.sv
module chop_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n, tick_en, pwm_en, trip_i, decay_slow_i;
  logic drive_on_o, recirc_slow_o;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  logic  q_drv[$];
  logic  q_slw[$];
  string q_tag[$];

  always #10 clk = ~clk;

  chop_ctrl #(.CNT_W(8), .OFF_TICKS(5), .BLANK_TICKS(3), .MIN_OFF_TICKS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwm_en(pwm_en),
    .trip_i(trip_i), .decay_slow_i(decay_slow_i),
    .drive_on_o(drive_on_o), .recirc_slow_o(recirc_slow_o)
  );

  task automatic cmp(input logic act_d, input logic act_s,
                     input logic exp_d, input logic exp_s, input string tag);
    checks++;
    if (act_d !== exp_d || act_s !== exp_s) begin
      errors++;
      $display("FAIL %s: drive=%b slow=%b expected drive=%b slow=%b at %0t",
               tag, act_d, act_s, exp_d, exp_s, $time);
    end
  endtask

  // driver: apply one cycle of inputs and queue the outputs due after the next edge
  task automatic step(input logic p, input logic t, input logic s, input logic k,
                      input logic ed, input logic es, input string tag);
    pwm_en = p; trip_i = t; decay_slow_i = s; tick_en = k;
    q_drv.push_back(ed); q_slw.push_back(es); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q_drv.size() > 0) begin
      logic ed, es;
      string tg;
      ed = q_drv.pop_front(); es = q_slw.pop_front(); tg = q_tag.pop_front();
      cmp(drive_on_o, recirc_slow_o, ed, es, tg);
    end
  end

  initial begin
    rst_n = 1'b0; pwm_en = 1'b1; trip_i = 1'b0; decay_slow_i = 1'b1; tick_en = 1'b1;
    repeat (3) @(negedge clk);
    cmp(drive_on_o, recirc_slow_o, 1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;
    // R1: power-up minimum off of 4 ticks
    step(1,0,1,1, 0,0, "R1 min off");
    step(1,0,1,1, 0,0, "R1 min off");
    step(1,0,1,1, 0,0, "R1 min off");
    step(1,0,1,1, 1,0, "R1 turn on");
    // R3: trips during 3 blanking ticks ignored, 4th honoured
    step(1,1,1,1, 1,0, "R3 blank");
    step(1,1,1,1, 1,0, "R3 blank");
    step(1,1,1,1, 1,0, "R3 blank");
    step(1,1,1,1, 0,1, "R2 trip off slow R8");
    // R4: trip during off ignored, R2 off of 5 ticks
    step(1,1,1,1, 0,1, "R4 trip in off");
    step(1,0,1,1, 0,1, "R2 off");
    step(1,0,1,1, 0,1, "R2 off");
    step(1,0,1,1, 0,1, "R2 off");
    step(1,0,1,1, 1,0, "R2 R4 resume");
    step(1,0,1,1, 1,0, "R2 on");
    step(1,0,1,1, 1,0, "R2 on");
    step(1,0,1,1, 1,0, "R2 on");
    // R7: pwm low during trip off turns into full off, count kept
    step(1,1,1,1, 0,1, "R8 slow off");
    step(0,0,1,1, 0,0, "R7 full off");
    step(1,0,1,1, 0,0, "R7 kept count");
    step(1,0,1,1, 0,0, "R7 kept count");
    step(1,0,1,1, 0,0, "R7 kept count");
    step(0,0,1,1, 0,0, "R5 expired pwm low");
    step(1,0,1,1, 1,0, "R5 resume on pwm");
    // R6: one-cycle pwm low gives 4 ticks of off
    step(0,0,1,1, 0,0, "R6 pwm off");
    step(1,0,1,1, 0,0, "R6 min off");
    step(1,0,1,1, 0,0, "R6 min off");
    step(1,0,1,1, 0,0, "R6 min off");
    step(1,0,1,1, 1,0, "R6 resume");
    // R10: blanking reloaded after pwm turn-on
    step(1,1,0,1, 1,0, "R10 blank");
    step(1,0,0,1, 1,0, "R10 blank");
    step(1,0,0,1, 1,0, "R10 blank");
    step(1,1,0,1, 0,0, "R8 fast trip off");
    // R9: no ticks, count holds
    step(1,0,0,0, 0,0, "R9 hold");
    step(1,0,0,0, 0,0, "R9 hold");
    step(1,0,0,0, 0,0, "R9 hold");
    step(1,0,0,1, 0,0, "R9 off");
    step(1,0,0,1, 0,0, "R9 off");
    step(1,0,0,1, 0,0, "R9 off");
    step(1,0,0,1, 0,0, "R9 off");
    step(1,0,0,1, 1,0, "R9 resume");
    step(1,1,0,0, 1,0, "R9 R3 blank holds");
    step(0,0,0,1, 0,0, "R6 pwm off");
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule